// File: doc/BRIEF.md
# ALU Status Flag Generator

This block produces the condition flags for a 16-bit integer datapath. On each cycle where the update enable is high, it takes the two ALU operands, the ALU result, the ALU carry-out, an operation class and a byte/word size select. From these it registers six arithmetic flags: carry, parity, auxiliary carry, zero, sign and overflow. When the update enable is low, those flags keep their values.

Alongside the arithmetic flags, the block stores three control flags: trap, interrupt-enable and direction. A separate command port sets or clears each of them. All nine flags are packed into one registered 16-bit word. The block also registers a signed index step for string operations. The sign of the step comes from the direction flag, and its size comes from the operand size.

Top module: `status_flag_unit`

## Requirements
- R1: After synchronous reset, `flags` is 0x0000 and `str_step` is 3'b001 (+1).
- R2: The flag word layout is carry bit 0, parity bit 1, auxiliary bit 2, zero bit 3, sign bit 4, overflow bit 5, trap bit 6, interrupt-enable bit 7, direction bit 8. Bits 15..9 always read 0.
- R3: Parity is 1 when the low 8 bits of the result hold an even number of ones, and 0 when they hold an odd number. This holds for both sizes.
- R4: Zero is 1 exactly when the active part of the result is zero. The active part is bits 7..0 for a byte and bits 15..0 for a word. Sign copies the top bit of the active part, which is bit 7 or bit 15.
- R5: For add (op 2'b00) and subtract (op 2'b01), carry copies `alu_cout`. Auxiliary is a XOR b XOR result at bit 4, which is the carry or borrow between bits 3 and 4.
- R6: Overflow on add is set when the operand signs are equal and the result sign differs from them. On subtract, it is set when the operand signs differ and the result sign differs from operand a. Signs are taken at bit 7 or bit 15 according to size.
- R7: A logic operation (op 2'b10 or 2'b11) clears carry, overflow and auxiliary.
- R8: Bits 5..0 change only after a clock edge where `upd_en` is 1. Otherwise they hold.
- R9: When `ctl_we` is 1, the control flag chosen by `ctl_sel` takes the value of `ctl_val`. `ctl_sel` selects trap with 0, interrupt-enable with 1 and direction with 2; the value 3 changes nothing. The other control flags hold.
- R10: `str_step` is a 3-bit two's-complement step registered each cycle. Its sign comes from the post-edge direction flag: 0 gives a positive step and 1 a negative one. Its size is 2 when `word_sz` is 1 and 1 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Capture arithmetic flags this cycle |
| op_cls | input | 2 | 0 add, 1 subtract, 2/3 logic |
| word_sz | input | 1 | 1 word, 0 byte |
| opnd_a | input | 16 | First ALU operand |
| opnd_b | input | 16 | Second ALU operand |
| alu_res | input | 16 | ALU result |
| alu_cout | input | 1 | ALU carry/borrow out of the active size |
| ctl_we | input | 1 | Control flag write strobe |
| ctl_sel | input | 2 | Control flag select |
| ctl_val | input | 1 | Value for the selected control flag |
| flags | output | 16 | Packed registered flag word |
| str_step | output | 3 | Signed string index step |

## Verification
Random operands are driven through real add, subtract and AND results in both sizes. This exposes any mix-up between the add and subtract overflow rules, and any mistake in choosing the sign bit for each size. Directed cases cover the following:
- 0x7F+1 and 0x7FFF+1, which overflow in one size only.
- 0x0F+1 for the nibble carry.
- A zero word whose high byte alone is nonzero, which separates byte zero from word zero.
- Results of 0x00FF and 0x0100, which show that parity reads only the low byte.

Idle cycles with changing inputs show the hold behaviour. Walking the four control selects, in both directions and both sizes, separates the four step values.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_LOG = 2'b10,
    OP_LGX = 2'b11
  } op_cls_t;

  typedef enum logic [1:0] {
    CS_TRAP = 2'b00,
    CS_IEN  = 2'b01,
    CS_DIR  = 2'b10,
    CS_NONE = 2'b11
  } ctl_sel_t;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } arith_flags_t;

  localparam int unsigned POS_CRY = 0;
  localparam int unsigned POS_PAR = 1;
  localparam int unsigned POS_AUX = 2;
  localparam int unsigned POS_ZER = 3;
  localparam int unsigned POS_SGN = 4;
  localparam int unsigned POS_OVF = 5;
  localparam int unsigned POS_TRP = 6;
  localparam int unsigned POS_IEN = 7;
  localparam int unsigned POS_DIR = 8;
  localparam int unsigned N_USED  = 9;
endpackage

// File: rtl/flagu_arith.sv
module flagu_arith
  import flagu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PAR_W  = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  input  logic              cout,
  input  logic [1:0]        op,
  input  logic              word,
  output arith_flags_t      fl
);
  localparam int unsigned HALF = DATA_W / 2;

  logic sa, sb, sr;
  logic zw, zb;
  logic is_add, is_sub;

  always_comb begin
    is_add = (op == OP_ADD);
    is_sub = (op == OP_SUB);
    sa = word ? a[DATA_W-1] : a[HALF-1];
    sb = word ? b[DATA_W-1] : b[HALF-1];
    sr = word ? r[DATA_W-1] : r[HALF-1];
    zw = (r == '0);
    zb = (r[HALF-1:0] == '0);

    fl.par = ~(^r[PAR_W-1:0]);
    fl.zer = word ? zw : zb;
    fl.sgn = sr;
    fl.cry = (is_add | is_sub) & cout;
    fl.aux = (is_add | is_sub) & (a[NIB_W] ^ b[NIB_W] ^ r[NIB_W]);
    if (is_add)      fl.ovf = (sa == sb) && (sr != sa);
    else if (is_sub) fl.ovf = (sa != sb) && (sr != sa);
    else             fl.ovf = 1'b0;
  end
endmodule

// File: rtl/flagu_ctrl.sv
module flagu_ctrl
  import flagu_pkg::*;
#(
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic              val,
  input  logic              word,
  output logic              trp,
  output logic              ien,
  output logic              dir,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);
  localparam logic [STEP_W-1:0] TWO = STEP_W'(2);

  logic trp_n, ien_n, dir_n;
  logic [STEP_W-1:0] mag;

  always_comb begin
    trp_n = trp;
    ien_n = ien;
    dir_n = dir;
    if (we) begin
      case (sel)
        CS_TRAP: trp_n = val;
        CS_IEN:  ien_n = val;
        CS_DIR:  dir_n = val;
        default: ;
      endcase
    end
    mag = word ? TWO : ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trp  <= 1'b0;
      ien  <= 1'b0;
      dir  <= 1'b0;
      step <= ONE;
    end else begin
      trp  <= trp_n;
      ien  <= ien_n;
      dir  <= dir_n;
      step <= dir_n ? (~mag + ONE) : mag;
    end
  end

  AST_STEP_SIGN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (step[STEP_W-1] == dir)); // R10
  AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (step != '0)); // R10
  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && sel == CS_IEN) |=> (ien == $past(val))); // R9
  AST_CTL_NOOP: assert property (@(posedge clk) disable iff (rst)
    (!we || sel == CS_NONE) |=> ($stable(trp) && $stable(ien) && $stable(dir))); // R9
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import flagu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FLAG_W = 16,
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [1:0]        op_cls,
  input  logic              word_sz,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_sel,
  input  logic              ctl_val,
  output logic [FLAG_W-1:0] flags,
  output logic [STEP_W-1:0] str_step
);
  localparam int unsigned PAD_W = FLAG_W - N_USED;

  arith_flags_t af_next, af_q;
  logic trp, ien, dir;

  flagu_arith #(.DATA_W(DATA_W)) u_arith (
    .a(opnd_a), .b(opnd_b), .r(alu_res), .cout(alu_cout),
    .op(op_cls), .word(word_sz), .fl(af_next)
  );

  flagu_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctl_we), .sel(ctl_sel), .val(ctl_val),
    .word(word_sz), .trp(trp), .ien(ien), .dir(dir), .step(str_step)
  );

  always_ff @(posedge clk) begin
    if (rst)         af_q <= '0;
    else if (upd_en) af_q <= af_next;
  end

  always_comb begin
    flags          = '0;
    flags[POS_CRY] = af_q.cry;
    flags[POS_PAR] = af_q.par;
    flags[POS_AUX] = af_q.aux;
    flags[POS_ZER] = af_q.zer;
    flags[POS_SGN] = af_q.sgn;
    flags[POS_OVF] = af_q.ovf;
    flags[POS_TRP] = trp;
    flags[POS_IEN] = ien;
    flags[POS_DIR] = dir;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(flags[POS_OVF:POS_CRY])); // R8
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_cls[1]) |=> (!flags[POS_CRY] && !flags[POS_OVF] && !flags[POS_AUX])); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    flags[FLAG_W-1:N_USED] == PAD_W'(0)); // R2
  AST_ZERO_IMPLIES: assert property (@(posedge clk) disable iff (rst)
    flags[POS_ZER] |-> (flags[POS_PAR] && !flags[POS_SGN])); // R4
endmodule

// File: tb/sim_status_flag_unit.sv
module sim_status_flag_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_en = 1'b0;
  logic [1:0] op_cls = 2'b00;
  logic word_sz = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
  logic alu_cout = 1'b0;
  logic ctl_we = 1'b0;
  logic [1:0] ctl_sel = 2'b00;
  logic ctl_val = 1'b0;
  logic [15:0] flags;
  logic [2:0] str_step;

  int n_chk = 0, n_bad = 0;
  logic [5:0] m_ar = '0;
  logic m_t = 0, m_i = 0, m_d = 0;
  logic [2:0] m_step = 3'b001;

  always #10 clk = ~clk;

  status_flag_unit u0 (
    .clk, .rst, .upd_en, .op_cls, .word_sz, .opnd_a, .opnd_b, .alu_res,
    .alu_cout, .ctl_we, .ctl_sel, .ctl_val, .flags, .str_step
  );

  function automatic logic [5:0] ref_ar(input logic [15:0] a, b, r,
                                        input logic c, input logic [1:0] op,
                                        input logic w);
    logic p, z, s, x, o, cy, sa, sb;
    int k;
    k = 0;
    for (int i = 0; i < 8; i++) k += r[i];
    p  = (k % 2 == 0);
    z  = w ? (r == 16'h0) : (r[7:0] == 8'h0);
    s  = w ? r[15] : r[7];
    sa = w ? a[15] : a[7];
    sb = w ? b[15] : b[7];
    cy = 0; x = 0; o = 0;
    if (op == 2'b00) begin
      cy = c; x = a[4] ^ b[4] ^ r[4]; o = (sa == sb) && (s != sa);
    end else if (op == 2'b01) begin
      cy = c; x = a[4] ^ b[4] ^ r[4]; o = (sa != sb) && (s != sa);
    end
    return {o, s, z, x, p, cy};
  endfunction

  function automatic logic [15:0] exp_word();
    return {7'b0, m_d, m_i, m_t, m_ar};
  endfunction

  task automatic check(input string req, input logic [15:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, model the next posedge, compare at the following negedge
  task automatic step_op(input logic u, input logic [1:0] op, input logic w,
                         input logic [15:0] a, b, input logic cw,
                         input logic [1:0] cs, input logic cv, input string req);
    logic [16:0] full;
    logic [15:0] r;
    logic c;
    full = '0;
    if (op == 2'b00) full = {1'b0, a} + {1'b0, b};
    else if (op == 2'b01) full = {1'b0, a} - {1'b0, b};
    else full = {1'b0, a & b};
    r = full[15:0];
    if (w) c = full[16];
    else c = (op == 2'b00) ? ((a[7:0] + b[7:0]) > 9'hFF) : (a[7:0] < b[7:0]);
    upd_en = u; op_cls = op; word_sz = w; opnd_a = a; opnd_b = b;
    alu_res = r; alu_cout = c; ctl_we = cw; ctl_sel = cs; ctl_val = cv;
    if (u) m_ar = ref_ar(a, b, r, c, op, w);
    if (cw) begin
      if (cs == 2'b00) m_t = cv;
      else if (cs == 2'b01) m_i = cv;
      else if (cs == 2'b10) m_d = cv;
    end
    m_step = m_d ? (w ? 3'b110 : 3'b111) : (w ? 3'b010 : 3'b001);
    @(negedge clk);
    check(req, flags, exp_word());
    check("R10", {13'b0, str_step}, {13'b0, m_step});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check("R1", flags, 16'h0000);
    check("R1", {13'b0, str_step}, 16'h0001);
    rst = 0;
    // directed corners
    step_op(1, 2'b00, 0, 16'h007F, 16'h0001, 0, 0, 0, "R6");   // byte ovf
    step_op(1, 2'b00, 1, 16'h007F, 16'h0001, 0, 0, 0, "R6");   // no word ovf
    step_op(1, 2'b00, 1, 16'h7FFF, 16'h0001, 0, 0, 0, "R6");   // word ovf
    step_op(1, 2'b01, 1, 16'h8000, 16'h0001, 0, 0, 0, "R6");   // sub ovf
    step_op(1, 2'b00, 0, 16'h000F, 16'h0001, 0, 0, 0, "R5");   // aux
    step_op(1, 2'b01, 0, 16'h0010, 16'h0001, 0, 0, 0, "R5");   // borrow
    step_op(1, 2'b00, 0, 16'h0100, 16'h0000, 0, 0, 0, "R4");   // byte zero
    step_op(1, 2'b00, 1, 16'h0100, 16'h0000, 0, 0, 0, "R4");   // word nonzero
    step_op(1, 2'b10, 1, 16'h00FF, 16'hFFFF, 0, 0, 0, "R3");   // parity even
    step_op(1, 2'b10, 1, 16'hFFFE, 16'hFFFF, 0, 0, 0, "R3");   // parity odd
    step_op(1, 2'b00, 0, 16'h00FF, 16'h0001, 0, 0, 0, "R5");   // carry
    step_op(1, 2'b11, 1, 16'hFFFF, 16'h8F0F, 0, 0, 0, "R7");
    step_op(0, 2'b01, 1, 16'h1234, 16'h5678, 0, 0, 0, "R8");   // hold
    step_op(0, 2'b00, 0, 16'h0000, 16'h0000, 0, 0, 0, "R8");
    // control flags and step in every combination
    step_op(0, 2'b00, 0, 0, 0, 1, 2'b00, 1, "R9");
    step_op(0, 2'b00, 0, 0, 0, 1, 2'b01, 1, "R9");
    step_op(0, 2'b00, 0, 0, 0, 1, 2'b11, 0, "R9");
    step_op(0, 2'b00, 1, 0, 0, 0, 2'b10, 1, "R10");
    step_op(0, 2'b00, 1, 0, 0, 1, 2'b10, 1, "R10");
    step_op(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, "R10");
    step_op(1, 2'b01, 1, 16'h0005, 16'h0009, 1, 2'b00, 0, "R2");
    step_op(0, 2'b00, 0, 0, 0, 1, 2'b10, 0, "R10");
    // random mix
    for (int i = 0; i < 400; i++) begin
      step_op($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
              $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), "R2");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule